// File: doc/BRIEF.md
# Write-Protection Unlock Sequence Detector

This block sits on the write-event path of a byte-wide nonvolatile memory port. It decides, write by write, whether the array may store the byte on the bus. It also keeps a persistent protect flag that software sets and clears with short command sequences. Two sequences are recognised. The first is an arming sequence of three command writes. It sets protection, and it also unlocks the page load that follows it. The second is a six-write disarm sequence, which clears protection.

Writes arrive as single-cycle strobes carrying an address and a data byte. A window signal from the external page-load timer reports whether the current write follows the previous one closely enough. A load phase starts with the first data write, or with a completed command sequence. It ends when the window closes. At that moment the block pulses the programming-timer start and runs a busy interval. A protected change only takes effect when that busy interval ends. A data write that protection rejects still opens a load phase, so it still triggers the busy interval, but nothing is stored.

Top module: `wprot_seq`

## Requirements
- R1: After reset, `prot_on` equals parameter PROT_RST (default 0), `busy` is low, and `wr_permit` and `prog_start` are low while no write is presented.
- R2: While unprotected, a data write is permitted: `wr_permit` is high in the same cycle as its `wr_stb`.
- R3: The command writes are never permitted. Writes of 0xAA to 0x1555, 0x55 to 0x0AAA, then 0xA0 to 0x1555, completed while idle, arm protection. `prot_on` rises on the clock edge where `busy` falls after that load closes, and it changes at no other time.
- R4: While protected, a data write that does not directly follow the arming sequence gets no permit. Closing its load still pulses `prog_start` and runs `busy`.
- R5: While protected, every data write inside the load phase opened by a completed arming sequence is permitted, including several bytes of one page.
- R6: The disarm sequence clears protection after the busy interval, and data writes inside its load phase are permitted. The sequence is 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555.
- R7: A write that does not match the next expected command byte is handled as a data write: it is permitted only if unprotected, and it opens a load phase. The detector returns to its first step.
- R8: If `win_open` is low while a command sequence is part-way through, the partial progress is discarded, with no `prog_start` and no busy interval. The next write is decoded from the first step.
- R9: While `busy` is high, writes are ignored: no permit is given, and no load phase is opened.
- R10: `prog_start` is a single-cycle pulse in the cycle where `win_open` is low during a load phase. `busy` is then high for exactly BUSY_CYC cycles, starting on the next edge.
- R11: Inside a load phase every write is data, even one that matches a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write event |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data byte |
| win_open | input | 1 | High while the byte-load window since the previous write is still open |
| wr_permit | output | 1 | Array may store this write (same cycle as `wr_stb`) |
| prog_start | output | 1 | Pulse that starts the programming timer |
| busy | output | 1 | Programming interval in progress |
| prot_on | output | 1 | Protection state |

## Verification
`wr_permit` and `prog_start` are combinational, so each is due in the same cycle as the write or window-close that causes it. The bench drives each stimulus on the falling edge and samples 3 ns later, before the next rising edge. `busy` rises one edge after the `prog_start` cycle and then lasts BUSY_CYC samples. `prot_on` changes on the edge where `busy` drops. The bench therefore counts busy samples one per cycle, checks that `prot_on` holds its old value on the last busy sample, and checks the new value on the first sample where `busy` is low. Table vectors that close a load phase are followed by enough idle cycles for the busy interval to end, so that every vector is sampled while the block is not busy.

// File: rtl/wprot_seq.sv
module wprot_seq #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int BUSY_CYC = 16,
  parameter bit PROT_RST = 1'b0,
  parameter logic [AW-1:0] KEY_A1 = AW'('h1555),
  parameter logic [AW-1:0] KEY_A2 = AW'('h0AAA),
  parameter logic [DW-1:0] KEY_D1 = DW'('hAA),
  parameter logic [DW-1:0] KEY_D2 = DW'('h55),
  parameter logic [DW-1:0] ARM_D  = DW'('hA0),
  parameter logic [DW-1:0] DIS_D0 = DW'('h80),
  parameter logic [DW-1:0] DIS_D  = DW'('h20)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          win_open,
  output logic          wr_permit,
  output logic          prog_start,
  output logic          busy,
  output logic          prot_on
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [2:0]    step, step_n;
  logic          loading, qual, nxt_prot;
  logic [CW-1:0] cnt;
  logic          cmd_ok, arm, dis;

  wire on_a1 = wr_addr == KEY_A1;
  wire on_a2 = wr_addr == KEY_A2;
  wire m_k1  = on_a1 && wr_data == KEY_D1;
  wire m_k2  = on_a2 && wr_data == KEY_D2;
  wire m_arm = on_a1 && wr_data == ARM_D;
  wire m_d0  = on_a1 && wr_data == DIS_D0;
  wire m_dis = on_a1 && wr_data == DIS_D;

  assign busy = cnt != '0;

  wire expire  = !busy && (loading || step != 3'd0) && !win_open;
  wire wr_ev   = wr_stb && !busy && !expire;
  wire seq_wr  = wr_ev && !loading && cmd_ok;
  wire data_wr = wr_ev && (loading || !cmd_ok);

  assign wr_permit  = data_wr && (loading ? qual : !prot_on);
  assign prog_start = expire && loading;

  always_comb begin
    cmd_ok = 1'b0;
    step_n = 3'd0;
    arm    = 1'b0;
    dis    = 1'b0;
    case (step)
      3'd0: if (m_k1) begin cmd_ok = 1'b1; step_n = 3'd1; end
      3'd1: if (m_k2) begin cmd_ok = 1'b1; step_n = 3'd2; end
      3'd2: begin
        if (m_arm) begin
          cmd_ok = 1'b1;
          arm    = 1'b1;
        end else if (m_d0) begin
          cmd_ok = 1'b1;
          step_n = 3'd3;
        end
      end
      3'd3: if (m_k1) begin cmd_ok = 1'b1; step_n = 3'd4; end
      3'd4: if (m_k2) begin cmd_ok = 1'b1; step_n = 3'd5; end
      3'd5: if (m_dis) begin cmd_ok = 1'b1; dis = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= 3'd0;
      loading  <= 1'b0;
      qual     <= 1'b0;
      cnt      <= '0;
      prot_on  <= PROT_RST;
      nxt_prot <= PROT_RST;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) prot_on <= nxt_prot;
    end else if (expire) begin
      step    <= 3'd0;
      loading <= 1'b0;
      if (loading) cnt <= CW'(BUSY_CYC);
    end else if (seq_wr) begin
      step <= step_n;
      if (arm || dis) begin
        loading  <= 1'b1;
        qual     <= 1'b1;
        nxt_prot <= arm;
      end
    end else if (data_wr && !loading) begin
      step    <= 3'd0;
      loading <= 1'b1;
      qual    <= !prot_on;
    end
  end
endmodule

// File: rtl/wprot_seq_chk.sv
module wprot_seq_chk #(
  parameter int BUSY_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic wr_permit,
  input logic prog_start,
  input logic busy,
  input logic prot_on
);
  localparam int BW = $clog2(BUSY_CYC + 2);
  logic [BW-1:0] bc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc <= '0;
    else if (busy) bc <= bc + BW'(1);
    else bc <= '0;
  end

  p_permit_on_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> wr_stb);

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_permit);

  p_prog_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  p_prog_then_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy);

  p_busy_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_start));

  p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bc == BW'(BUSY_CYC));

  p_prot_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on != $past(prot_on)) |-> ($past(busy) && !busy));
endmodule

bind wprot_seq wprot_seq_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_permit(wr_permit),
  .prog_start(prog_start), .busy(busy), .prot_on(prot_on)
);

// File: tb/wprot_seq_bench.sv
module wprot_seq_bench;
  localparam int BUSY = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic win_open = 1'b0;
  logic wr_permit, prog_start, busy, prot_on;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wprot_seq u_wprot_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_open(win_open), .wr_permit(wr_permit),
    .prog_start(prog_start), .busy(busy), .prot_on(prot_on)
  );

  typedef struct packed {
    logic        stb;
    logic        win;
    logic [12:0] a;
    logic [7:0]  d;
    logic        perm;
    logic        prog;
    logic        prot;
    logic [4:0]  hold;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,13'h0100,8'h11,1'b1,1'b0,1'b0,5'd0,4'd2},   // R2 data while unprotected
    '{1'b1,1'b1,13'h1555,8'hAA,1'b1,1'b0,1'b0,5'd0,4'd11},  // R11 key byte inside load
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b0,5'd18,4'd10}, // R10 close
    '{1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b0,5'd0,4'd3},   // R3 arm
    '{1'b1,1'b1,13'h0AAA,8'h55,1'b0,1'b0,1'b0,5'd0,4'd3},
    '{1'b1,1'b1,13'h1555,8'hA0,1'b0,1'b0,1'b0,5'd0,4'd3},
    '{1'b1,1'b1,13'h0040,8'h5A,1'b1,1'b0,1'b0,5'd0,4'd5},   // R5
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b0,5'd18,4'd10},
    '{1'b1,1'b0,13'h0200,8'h77,1'b0,1'b0,1'b1,5'd0,4'd4},   // R4 rejected
    '{1'b1,1'b1,13'h0201,8'h78,1'b0,1'b0,1'b1,5'd0,4'd4},
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,5'd18,4'd4},  // R4 timer still starts
    '{1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,5'd0,4'd5},   // R5 unlocked page
    '{1'b1,1'b1,13'h0AAA,8'h55,1'b0,1'b0,1'b1,5'd0,4'd5},
    '{1'b1,1'b1,13'h1555,8'hA0,1'b0,1'b0,1'b1,5'd0,4'd5},
    '{1'b1,1'b1,13'h1000,8'h01,1'b1,1'b0,1'b1,5'd0,4'd5},
    '{1'b1,1'b1,13'h1001,8'h02,1'b1,1'b0,1'b1,5'd0,4'd5},
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,5'd18,4'd10},
    '{1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,5'd0,4'd7},   // R7 broken sequence
    '{1'b1,1'b1,13'h0AAA,8'h33,1'b0,1'b0,1'b1,5'd0,4'd7},
    '{1'b1,1'b1,13'h1555,8'hA0,1'b0,1'b0,1'b1,5'd0,4'd7},
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,5'd18,4'd7},
    '{1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,5'd0,4'd8},   // R8 timeout mid-sequence
    '{1'b1,1'b1,13'h0AAA,8'h55,1'b0,1'b0,1'b1,5'd0,4'd8},
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b1,5'd0,4'd8},
    '{1'b1,1'b1,13'h1555,8'hA0,1'b0,1'b0,1'b1,5'd0,4'd8},
    '{1'b1,1'b1,13'h0300,8'h99,1'b0,1'b0,1'b1,5'd0,4'd8},
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,5'd18,4'd8},
    '{1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,5'd0,4'd6},   // R6 disarm
    '{1'b1,1'b1,13'h0AAA,8'h55,1'b0,1'b0,1'b1,5'd0,4'd6},
    '{1'b1,1'b1,13'h1555,8'h80,1'b0,1'b0,1'b1,5'd0,4'd6},
    '{1'b1,1'b1,13'h1555,8'hAA,1'b0,1'b0,1'b1,5'd0,4'd6},
    '{1'b1,1'b1,13'h0AAA,8'h55,1'b0,1'b0,1'b1,5'd0,4'd6},
    '{1'b1,1'b1,13'h1555,8'h20,1'b0,1'b0,1'b1,5'd0,4'd6},
    '{1'b1,1'b1,13'h0400,8'h44,1'b1,1'b0,1'b1,5'd0,4'd6},
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,5'd18,4'd6},
    '{1'b1,1'b0,13'h0500,8'h55,1'b1,1'b0,1'b0,5'd0,4'd6},   // R6 cleared
    '{1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b0,5'd18,4'd10}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = s; win_open = w; wr_addr = a; wr_data = d;
    #3;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    #3;
    chk(prot_on == 1'b0, "R1 prot in reset", prot_on, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    chk(prot_on == 1'b0, "R1 prot", prot_on, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(wr_permit == 1'b0, "R1 permit", wr_permit, 0);
    chk(prog_start == 1'b0, "R1 prog", prog_start, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      cyc(TBL[i].stb, TBL[i].win, TBL[i].a, TBL[i].d);
      chk(wr_permit == TBL[i].perm, {tag, " permit"}, wr_permit, TBL[i].perm);
      chk(prog_start == TBL[i].prog, {tag, " prog"}, prog_start, TBL[i].prog);
      chk(prot_on == TBL[i].prot, {tag, " prot"}, prot_on, TBL[i].prot);
      chk(busy == 1'b0, {tag, " busy"}, busy, 0);
      for (int h = 0; h < TBL[i].hold; h++) cyc(0, 0, 0, 0);
    end

    // R9: write during busy is ignored and opens no load
    cyc(1, 0, 13'h0600, 8'h66);
    chk(wr_permit == 1'b1, "R9 setup permit", wr_permit, 1);
    cyc(0, 0, 0, 0);
    chk(prog_start == 1'b1, "R9 setup prog", prog_start, 1);
    repeat (3) cyc(0, 0, 0, 0);
    cyc(1, 1, 13'h0601, 8'h67);
    chk(wr_permit == 1'b0, "R9 permit during busy", wr_permit, 0);
    chk(busy == 1'b1, "R9 busy", busy, 1);
    for (int k = 0; k < 40 && busy; k++) cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk(prog_start == 1'b0, "R9 no load opened", prog_start, 0);

    // R3 / R10: arm while unprotected, exact busy length and commit point
    cyc(1, 0, 13'h1555, 8'hAA);
    chk(wr_permit == 1'b0, "R3 key1", wr_permit, 0);
    cyc(1, 1, 13'h0AAA, 8'h55);
    chk(wr_permit == 1'b0, "R3 key2", wr_permit, 0);
    cyc(1, 1, 13'h1555, 8'hA0);
    chk(wr_permit == 1'b0, "R3 arm", wr_permit, 0);
    cyc(0, 0, 0, 0);
    chk(prog_start == 1'b1, "R10 prog on close", prog_start, 1);
    nb = 0;
    for (int k = 0; k < 40; k++) begin
      cyc(0, 0, 0, 0);
      if (!busy) break;
      nb++;
      chk(prot_on == 1'b0, "R3 prot held while busy", prot_on, 0);
      chk(prog_start == 1'b0, "R10 prog single", prog_start, 0);
    end
    chk(nb == BUSY, "R10 busy length", nb, BUSY);
    chk(prot_on == 1'b1, "R3 prot after busy", prot_on, 1);

    // R1: reset returns protection to its default
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk(prot_on == 1'b0, "R1 prot after re-reset", prot_on, 0);
    chk(busy == 1'b0, "R1 busy after re-reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 13'h0700, 8'h70);
    chk(wr_permit == 1'b1, "R1 unprotected after reset", wr_permit, 1);

    finish_run();
  end
endmodule